// File: doc/BRIEF.md
# Vector Load Up-Convert and Broadcast Unit

This block turns one 64-byte memory line into a sixteen-lane, 32-bit-per-lane register image. A request gives a byte offset inside the line, a storage format and a replication mode. The unit picks the needed elements starting at that offset, widens each one to a 32-bit value, and repeats the group to fill all sixteen lanes. Narrow integers are sign- or zero-extended and can then be turned into exact single-precision values. Half-precision values are always widened to single precision.

Replication and format conversion work together in one request. Each request is checked for alignment: the offset must be a multiple of the bytes actually read, which is the element count times the element size. A misaligned request, or one using an unassigned code, returns a fault with an all-zero vector.

The result is registered. A two-state controller (`ST_IDLE`, `ST_HOLD`) moves to `ST_HOLD` in any cycle that carries a request and to `ST_IDLE` in any cycle that does not. `out_valid` is high exactly while the controller is in `ST_HOLD`. Requests may arrive back to back.

Top module: `vload_upconv`

## Requirements
- R1: A request accepted on a clock edge produces `out_valid` high after that edge and for one cycle only. With no request, `out_valid` is low after the next edge. Back-to-back requests give back-to-back results.
- R2: With `req_bcast` = 1 (one-to-sixteen), the element at the offset is converted and placed in all sixteen lanes.
- R3: With `req_bcast` = 2 (four-to-sixteen), four consecutive elements starting at the offset fill lanes 0..3. That group repeats in lanes 4..7, 8..11 and 12..15.
- R4: With `req_bcast` = 0 (sixteen-to-sixteen), lane i takes the element i positions above the offset. Lane i sits in `out_vec[32i+31:32i]`, and bytes within an element are little-endian, so lane 0 comes from the lowest address.
- R5: `req_fmt` codes and sizes are 0 = 32-bit word (4 bytes), 1 = float16 (2), 2 = signed 8-bit, 3 = unsigned 8-bit, 4 = signed 16-bit and 5 = unsigned 16-bit. With `req_to_fp` = 0, codes 2 and 4 are sign-extended and codes 3 and 5 are zero-extended to 32 bits.
- R6: With `req_to_fp` = 1, codes 2 to 5 produce the exact IEEE single-precision value of the extended integer. Zero gives +0.0.
- R7: Code 1 always yields single precision, whatever `req_to_fp` is. Zeros keep their sign, normal values are exact, infinities stay infinities, and NaNs keep their payload, including the quiet bit.
- R8: Float16 subnormal inputs are normalised into exact single-precision normal values.
- R9: A request faults when the offset is not a multiple of (elements read × element size). Elements read are 1, 4 or 16. A faulting result has `out_fault` high and `out_vec` all zero. `out_fault` is never high without `out_valid`.
- R10: `req_fmt` codes 6 and 7 and `req_bcast` code 3 are unassigned, and a request that uses any of them faults.
- R11: During and right after reset, `out_valid` and `out_fault` are low and `out_vec` is zero.
- R12: Code 0 copies the 32-bit word unchanged, and `req_to_fp` has no effect on it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, one request per cycle |
| req_addr | input | 6 | Byte offset inside the line |
| req_fmt | input | 3 | Storage format code |
| req_bcast | input | 2 | Replication mode code |
| req_to_fp | input | 1 | Convert integer formats to single precision |
| line_data | input | 512 | Memory line, byte b at bits [8b+7:8b] |
| out_valid | output | 1 | Result strobe |
| out_fault | output | 1 | Misaligned or unassigned request |
| out_vec | output | 512 | Sixteen 32-bit result lanes |

## Verification
The properties assume that `line_data` and the request fields are stable and meaningful only in cycles where `req_valid` is high. They also assume the offset is a plain byte position that never wraps past the line. The stimulus drives every field on the falling edge together with `req_valid`, rebuilds the line from the bench's own byte array before each request, and drops `req_valid` between bursts. Every offset it uses lies inside the line. Misaligned and unassigned codes are sent on purpose only to exercise the fault path.

// File: rtl/vload_upconv_pkg.sv
package vload_upconv_pkg;

    typedef enum logic [2:0] {
        FMT_W32 = 3'd0,
        FMT_F16 = 3'd1,
        FMT_S8  = 3'd2,
        FMT_U8  = 3'd3,
        FMT_S16 = 3'd4,
        FMT_U16 = 3'd5
    } fmt_e;

    typedef enum logic [1:0] {
        BC_FULL = 2'd0,
        BC_ONE  = 2'd1,
        BC_QUAD = 2'd2,
        BC_RSVD = 2'd3
    } bc_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } state_e;

    // log2 of the storage size in bytes
    function automatic logic [1:0] size_log2(fmt_e f);
        logic [1:0] r;
        unique case (f)
            FMT_S8, FMT_U8:            r = 2'd0;
            FMT_F16, FMT_S16, FMT_U16: r = 2'd1;
            default:                   r = 2'd2;
        endcase
        return r;
    endfunction

    // log2 of the number of elements read from memory
    function automatic logic [2:0] count_log2(bc_e b);
        logic [2:0] r;
        unique case (b)
            BC_ONE:  r = 3'd0;
            BC_QUAD: r = 3'd2;
            default: r = 3'd4;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/vload_decode.sv
module vload_decode
    import vload_upconv_pkg::*;
#(
    parameter int OFS_W = 6
) (
    input  logic [OFS_W-1:0] addr,
    input  fmt_e             fmt,
    input  bc_e              bcast,
    output logic             fault
);
    logic             rsvd;
    logic [2:0]       need_log;
    logic [OFS_W:0]   need_mask;

    always_comb begin
        rsvd      = (fmt > FMT_U16) || (bcast == BC_RSVD);
        need_log  = count_log2(bcast) + {1'b0, size_log2(fmt)};
        need_mask = ((OFS_W+1)'(1) << need_log) - (OFS_W+1)'(1);
        fault     = rsvd || (|({1'b0, addr} & need_mask));
    end

endmodule

// File: rtl/vload_f16_widen.sv
module vload_f16_widen (
    input  logic [15:0] half_in,
    output logic [31:0] single_out
);
    logic       sgn;
    logic [4:0] ex;
    logic [9:0] man;
    logic [4:0] lead;

    always_comb begin
        sgn  = half_in[15];
        ex   = half_in[14:10];
        man  = half_in[9:0];
        lead = '0;
        for (int k = 0; k < 10; k++) begin
            if (man[k]) lead = 5'(k);
        end
        if (ex == 5'd31) begin
            single_out = {sgn, 8'hFF, man, 13'd0};
        end else if (ex != 5'd0) begin
            single_out = {sgn, 8'({3'd0, ex} + 8'd112), man, 13'd0};
        end else if (man == 10'd0) begin
            single_out = {sgn, 31'd0};
        end else begin
            single_out = {sgn, 8'(8'd103 + {3'd0, lead}),
                          23'({14'd0, man} << (5'd23 - lead))};
        end
    end

endmodule

// File: rtl/vload_lane.sv
module vload_lane
    import vload_upconv_pkg::*;
#(
    parameter int LINE_W   = 512,
    parameter int OFS_W    = 6,
    parameter int LANE_IDX = 0
) (
    input  logic [LINE_W-1:0] line,
    input  logic [OFS_W-1:0]  addr,
    input  fmt_e              fmt,
    input  bc_e               bcast,
    input  logic              to_fp,
    output logic [31:0]       elem
);
    localparam logic [OFS_W-1:0] FULL_IDX = OFS_W'(LANE_IDX);
    localparam logic [OFS_W-1:0] QUAD_IDX = OFS_W'(LANE_IDX % 4);

    logic [LINE_W+31:0] ext;
    logic [OFS_W-1:0]   src;
    logic [OFS_W-1:0]   off;
    logic [31:0]        raw;
    logic [31:0]        ival;
    logic [31:0]        fval;
    logic [31:0]        hval;
    logic               sgn;
    logic [16:0]        mag;
    logic [4:0]         lead;

    always_comb begin
        unique case (bcast)
            BC_ONE:  src = '0;
            BC_QUAD: src = QUAD_IDX;
            default: src = FULL_IDX;
        endcase
        off = addr + (src << size_log2(fmt));
        ext = {32'd0, line};
        raw = ext[{1'b0, off, 3'b000} +: 32];
    end

    always_comb begin
        unique case (fmt)
            FMT_S8:  ival = {{24{raw[7]}}, raw[7:0]};
            FMT_U8:  ival = {24'd0, raw[7:0]};
            FMT_S16: ival = {{16{raw[15]}}, raw[15:0]};
            FMT_U16: ival = {16'd0, raw[15:0]};
            default: ival = raw;
        endcase
    end

    // exact integer to single precision, magnitudes below 2^17
    always_comb begin
        sgn  = ival[31];
        mag  = sgn ? (17'd0 - ival[16:0]) : ival[16:0];
        lead = '0;
        for (int k = 0; k < 17; k++) begin
            if (mag[k]) lead = 5'(k);
        end
        if (mag == 17'd0) begin
            fval = '0;
        end else begin
            fval = {sgn, 8'(8'd127 + {3'd0, lead}),
                    23'({7'd0, mag} << (5'd23 - lead))};
        end
    end

    vload_f16_widen widen_i (
        .half_in    (raw[15:0]),
        .single_out (hval)
    );

    always_comb begin
        unique case (fmt)
            FMT_W32: elem = raw;
            FMT_F16: elem = hval;
            default: elem = to_fp ? fval : ival;
        endcase
    end

endmodule

// File: rtl/vload_upconv.sv
module vload_upconv
    import vload_upconv_pkg::*;
#(
    parameter  int NUM_ELEM   = 16,
    parameter  int ELEM_W     = 32,
    parameter  int LINE_BYTES = 64,
    localparam int LINE_W     = NUM_ELEM * ELEM_W,
    localparam int OFS_W      = $clog2(LINE_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [OFS_W-1:0]  req_addr,
    input  logic [2:0]        req_fmt,
    input  logic [1:0]        req_bcast,
    input  logic              req_to_fp,
    input  logic [LINE_W-1:0] line_data,
    output logic              out_valid,
    output logic              out_fault,
    output logic [LINE_W-1:0] out_vec
);
    fmt_e              fmt;
    bc_e               bcast;
    logic              fault;
    logic [LINE_W-1:0] lane_vec;
    state_e            state_q;
    state_e            state_d;

    assign fmt   = fmt_e'(req_fmt);
    assign bcast = bc_e'(req_bcast);

    vload_decode #(.OFS_W(OFS_W)) decode_i (
        .addr  (req_addr),
        .fmt   (fmt),
        .bcast (bcast),
        .fault (fault)
    );

    for (genvar g = 0; g < NUM_ELEM; g++) begin : g_lane
        vload_lane #(
            .LINE_W   (LINE_W),
            .OFS_W    (OFS_W),
            .LANE_IDX (g)
        ) lane_i (
            .line  (line_data),
            .addr  (req_addr),
            .fmt   (fmt),
            .bcast (bcast),
            .to_fp (req_to_fp),
            .elem  (lane_vec[g*ELEM_W +: ELEM_W])
        );
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_d = req_valid ? ST_HOLD : ST_IDLE;
            ST_HOLD: state_d = req_valid ? ST_HOLD : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_fault <= 1'b0;
            out_vec   <= '0;
        end else if (req_valid) begin
            out_fault <= fault;
            out_vec   <= fault ? '0 : lane_vec;
        end else begin
            out_fault <= 1'b0;
        end
    end

    assign out_valid = (state_q == ST_HOLD);

endmodule

// File: rtl/vload_upconv_chk.sv
module vload_upconv_chk #(
    parameter int NUM_ELEM = 16,
    parameter int ELEM_W   = 32,
    parameter int OFS_W    = 6
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       req_valid,
    input logic [OFS_W-1:0]           req_addr,
    input logic [2:0]                 req_fmt,
    input logic [1:0]                 req_bcast,
    input logic                       out_valid,
    input logic                       out_fault,
    input logic [NUM_ELEM*ELEM_W-1:0] out_vec
);
    AST_VALID_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> out_valid); // R1
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !out_valid); // R1
    AST_ONE_REPLICATES: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_fault && $past(req_bcast) == 2'd1)
        |-> out_vec == {NUM_ELEM{out_vec[ELEM_W-1:0]}}); // R2
    AST_QUAD_REPEATS: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_fault && $past(req_bcast) == 2'd2)
        |-> out_vec == {(NUM_ELEM/4){out_vec[4*ELEM_W-1:0]}}); // R3
    AST_FAULT_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        out_fault |-> out_vec == '0); // R9
    AST_FAULT_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        out_fault |-> out_valid); // R9
    AST_WORD_MISALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_fmt == 3'd0 && req_bcast == 2'd0 && req_addr != '0)
        |=> out_fault); // R9
    AST_RSVD_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_fmt > 3'd5 || req_bcast == 2'd3)) |=> out_fault); // R10
endmodule

bind vload_upconv vload_upconv_chk #(
    .NUM_ELEM (NUM_ELEM),
    .ELEM_W   (ELEM_W),
    .OFS_W    (OFS_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .req_fmt   (req_fmt),
    .req_bcast (req_bcast),
    .out_valid (out_valid),
    .out_fault (out_fault),
    .out_vec   (out_vec)
);

// File: tb/vload_upconv_tb_top.sv
module vload_upconv_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic [5:0]   req_addr = '0;
    logic [2:0]   req_fmt = '0;
    logic [1:0]   req_bcast = '0;
    logic         req_to_fp = 1'b0;
    logic [511:0] line_data = '0;
    logic         out_valid;
    logic         out_fault;
    logic [511:0] out_vec;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [7:0] mem [64];

    logic [511:0] pend_vec;
    logic         pend_fault;
    string        pend_tag;
    logic         exp_valid = 1'b0;
    logic [511:0] exp_vec = '0;
    logic         exp_fault = 1'b0;
    string        exp_tag = "R1";

    always #5 clk = ~clk;

    vload_upconv dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .req_fmt   (req_fmt),
        .req_bcast (req_bcast),
        .req_to_fp (req_to_fp),
        .line_data (line_data),
        .out_valid (out_valid),
        .out_fault (out_fault),
        .out_vec   (out_vec)
    );

    function automatic logic [31:0] real_to_sp(real r);
        logic [63:0] b;
        int e;
        b = $realtobits(r);
        e = int'(b[62:52]) - 1023 + 127;
        return {1'b0, 8'(e), b[51:29]};
    endfunction

    function automatic logic [31:0] int_to_sp(int v);
        logic [31:0] r;
        if (v == 0) return 32'd0;
        r = real_to_sp(real'(v < 0 ? -v : v));
        r[31] = (v < 0);
        return r;
    endfunction

    function automatic logic [31:0] half_to_sp(logic [15:0] h);
        int e;
        int m;
        real r;
        logic [31:0] o;
        e = int'(h[14:10]);
        m = int'(h[9:0]);
        if (e == 31) return {h[15], 8'hFF, h[9:0], 13'd0};
        if (e == 0 && m == 0) return {h[15], 31'd0};
        r = (e == 0) ? real'(m) : real'(1024 + m);
        r = r * (2.0 ** (((e == 0) ? 1 : e) - 25));
        o = real_to_sp(r);
        o[31] = h[15];
        return o;
    endfunction

    function automatic logic [31:0] ref_elem(int fmt, bit tofp, int a);
        int v;
        byte sb;
        shortint sh;
        case (fmt)
            0: return {mem[(a+3)%64], mem[(a+2)%64], mem[(a+1)%64], mem[a%64]};
            1: return half_to_sp({mem[(a+1)%64], mem[a%64]});
            2: begin sb = byte'(mem[a%64]); v = int'(sb); end
            3: v = int'(mem[a%64]);
            4: begin sh = shortint'({mem[(a+1)%64], mem[a%64]}); v = int'(sh); end
            default: v = int'({mem[(a+1)%64], mem[a%64]});
        endcase
        return tofp ? int_to_sp(v) : 32'(v);
    endfunction

    task automatic issue(int addr, int fmt, int bc, bit tofp, string tag);
        int sz;
        int cnt;
        int src;
        @(negedge clk);
        for (int b = 0; b < 64; b++) line_data[8*b +: 8] = mem[b];
        sz  = (fmt == 0) ? 4 : (fmt == 2 || fmt == 3) ? 1 : 2;
        cnt = (bc == 1) ? 1 : (bc == 2) ? 4 : 16;
        pend_fault = (fmt > 5) || (bc == 3) || ((addr % (cnt * sz)) != 0);
        pend_vec = '0;
        if (!pend_fault) begin
            for (int i = 0; i < 16; i++) begin
                src = (bc == 1) ? 0 : (bc == 2) ? i % 4 : i;
                pend_vec[32*i +: 32] = ref_elem(fmt, tofp, addr + src * sz);
            end
        end
        pend_tag  = tag;
        req_addr  = 6'(addr);
        req_fmt   = 3'(fmt);
        req_bcast = 2'(bc);
        req_to_fp = tofp;
        req_valid = 1'b1;
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            req_valid = 1'b0;
        end
    endtask

    // bench model: one-cycle registered result
    always @(posedge clk) begin
        if (!rst_n) begin
            exp_valid <= 1'b0;
            exp_fault <= 1'b0;
        end else begin
            exp_valid <= req_valid;
            exp_fault <= req_valid && pend_fault;
            if (req_valid) begin
                exp_vec <= pend_vec;
                exp_tag <= pend_tag;
            end else begin
                exp_tag <= "R1";
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (out_valid !== exp_valid || out_fault !== exp_fault ||
                (exp_valid && out_vec !== exp_vec)) begin
                failures++;
                $display("FAIL %s valid=%0b exp=%0b fault=%0b exp=%0b vec=%h exp=%h",
                         exp_tag, out_valid, exp_valid, out_fault, exp_fault,
                         out_vec, exp_vec);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [15:0] halves [16];
        halves = '{16'h0000, 16'h8000, 16'h3C00, 16'h0001, 16'h03FF, 16'h8200,
                   16'h7C00, 16'hFC00, 16'h7E01, 16'h7C01, 16'hC555, 16'h7BFF,
                   16'h0400, 16'h3555, 16'h1234, 16'hB800};
        for (int b = 0; b < 64; b++) mem[b] = 8'((b * 37 + 11) & 255);

        // R11: reset state
        repeat (3) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || out_fault !== 1'b0 || out_vec !== '0) begin
            failures++;
            $display("FAIL R11 valid=%0b fault=%0b vec=%h exp=0", out_valid, out_fault, out_vec);
        end
        rst_n = 1'b1;
        idle(2);

        issue(0, 0, 0, 0, "R4");       // full line of words
        issue(0, 0, 0, 1, "R12");      // to_fp has no effect on words
        issue(8, 0, 1, 0, "R2");       // one-to-sixteen word
        issue(16, 0, 2, 0, "R3");      // four-to-sixteen word
        idle(1);
        issue(16, 2, 0, 0, "R5");      // signed bytes to int
        issue(16, 2, 0, 1, "R6");      // signed bytes to float
        issue(5, 3, 1, 1, "R6");       // unsigned byte broadcast float
        issue(4, 3, 2, 0, "R5");       // unsigned byte quad int
        issue(8, 4, 2, 1, "R6");       // signed halfword quad float
        issue(32, 5, 0, 0, "R5");      // unsigned halfwords int
        issue(2, 4, 1, 0, "R5");       // signed halfword broadcast
        issue(62, 5, 1, 1, "R6");      // last halfword of line
        issue(63, 2, 1, 1, "R2");      // last byte of line
        idle(2);

        for (int k = 0; k < 16; k++) begin
            mem[2*k]   = halves[k][7:0];
            mem[2*k+1] = halves[k][15:8];
        end
        mem[40] = 8'h00; mem[41] = 8'h00; mem[42] = 8'hFF; mem[43] = 8'hFF;
        issue(0, 1, 0, 1, "R7");       // float16 specials
        issue(0, 1, 0, 0, "R7");       // target bit ignored for float16
        issue(6, 1, 1, 0, "R8");       // subnormal 0x0001 broadcast
        issue(8, 1, 2, 1, "R8");       // quad incl. 0x03FF subnormal
        issue(40, 2, 2, 1, "R6");      // zero and -1 bytes to float
        idle(1);

        issue(4, 0, 0, 0, "R9");       // word line at offset 4
        issue(4, 1, 2, 1, "R9");       // float16 quad needs 8-byte alignment
        issue(1, 5, 1, 0, "R9");       // odd halfword
        issue(32, 2, 0, 0, "R9");      // 16 bytes at 32: aligned, no fault
        issue(0, 6, 0, 0, "R10");
        issue(0, 7, 1, 0, "R10");
        issue(0, 0, 3, 0, "R10");
        issue(0, 0, 1, 0, "R1");       // clean request after faults
        idle(3);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule